// File: doc/BRIEF.md
# Receive Character Queue with Trigger and Idle Timeout

This block buffers received characters for one serial channel between the receiver's shift stage and the CPU. Each strobe on `wr_i` offers one character. A strobe on `rd_i` removes the oldest character. The oldest character is always visible on `rd_data_o` before it is read. The block has no serial framing and stores no error flags.

Two interrupt conditions are raised for the CPU. The first is a data-available flag: it is set while the stored count is at or above a threshold, which `trig_sel_i` picks from a fixed set of four uneven levels. The second is an idle timeout: it is set when a few characters sit below the threshold and nothing has been written or read for four character times. The character time is measured with the bit-time pulse `tick_i`.

With `fifo_en_i` low, the queue shrinks to a single holding register. In that mode the threshold is one character and the timeout is never raised. Software can empty the queue with `flush_i`.

Top module: `rx_char_queue`

## Requirements
- R1: After reset the block shows `count_o` = 0, `empty_o` = 1, and `full_o`, `overrun_o`, `data_irq_o` and `timeout_irq_o` all at 0.
- R2: With `fifo_en_i` = 1 the queue holds up to 16 characters and returns them oldest first. `rd_data_o` shows the oldest character before it is read. `count_o` follows each accepted write and read on the next clock edge. `full_o` is 1 exactly when the count equals the capacity.
- R3: A write while full is discarded and sets `overrun_o`. When the write comes alone, the stored characters and the count do not change. When a read comes in the same cycle, the read frees a slot and the write is accepted. `overrun_o` stays set until `flush_i` or reset.
- R4: A read while empty is ignored, and the count stays at 0.
- R5: `trig_sel_i` codes 2'b00, 2'b01, 2'b10 and 2'b11 select thresholds of 1, 4, 8 and 14 characters. `data_irq_o` is 1 exactly while `count_o` is at or above the selected threshold.
- R6: With `fifo_en_i` = 0 the capacity is one character, so `full_o` is set at a count of 1. The threshold is 1 whatever `trig_sel_i` says, and `timeout_irq_o` stays 0.
- R7: With `fifo_en_i` = 1 and a count between 1 and the threshold minus one, `timeout_irq_o` is set at the clock edge that samples the 40th `tick_i` pulse (4 characters of 10 bit times) after the last write or read.
- R8: Any `wr_i` strobe, or any read of a non-empty queue, clears `timeout_irq_o` on the next edge and restarts the 40-tick count.
- R9: `flush_i` empties the queue and clears `overrun_o` and `timeout_irq_o`. A change of `fifo_en_i` also empties the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | 1: 16-deep queue, 0: single holding register |
| flush_i | input | 1 | Empties the queue and clears the flags |
| trig_sel_i | input | 2 | Threshold select |
| tick_i | input | 1 | One-cycle pulse per bit time |
| wr_i | input | 1 | Character strobe from the receiver |
| wr_data_i | input | 8 | Received character |
| rd_i | input | 1 | CPU read strobe |
| rd_data_o | output | 8 | Oldest stored character |
| count_o | output | 5 | Stored character count |
| empty_o | output | 1 | Queue is empty |
| full_o | output | 1 | Queue is at capacity |
| overrun_o | output | 1 | Sticky flag: a character was discarded |
| data_irq_o | output | 1 | Count is at or above the threshold |
| timeout_irq_o | output | 1 | Idle timeout below the threshold |

## Verification
The hardest conditions to reach are the timeout boundary and its restart. The bench must hold the queue below the threshold and send exactly 39 and then 40 bit-time pulses with no traffic in between. It must then show that a single read or write starts the full window again. The bench does this with directed sequences: `tick_i` is held high for counted cycles after a write or read made with `tick_i` low, so the tick count at each check is exact. An overflow with its discarded character is also hard to reach. The bench gets there by filling all 16 slots at the highest threshold before offering one more character.

// File: rtl/rcq_pkg.sv
package rcq_pkg;
  // receive threshold decode; the order is part of the programming model
  function automatic int unsigned trig_level(input logic [1:0] sel);
    case (sel)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction
endpackage

// File: rtl/rcq_store.sv
module rcq_store #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              cap_one_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              wr_ok_o,
  output logic              rd_ok_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wptr_q, rptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cap;

  assign cap       = cap_one_i ? CNT_W'(1) : CNT_W'(DEPTH);
  assign empty_o   = (cnt_q == '0);
  assign full_o    = (cnt_q >= cap);
  assign rd_ok_o   = rd_i && !empty_o;
  assign wr_ok_o   = wr_i && (!full_o || rd_ok_o);
  assign rd_data_o = mem_q[rptr_q];
  assign count_o   = cnt_q;

  always_ff @(posedge clk_i) begin
    if (wr_ok_o && !clr_i) mem_q[wptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_ok_o) wptr_q <= wptr_q + PTR_W'(1);
      if (rd_ok_o) rptr_q <= rptr_q + PTR_W'(1);
      case ({wr_ok_o, rd_ok_o})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/rcq_trigger.sv
module rcq_trigger #(
  parameter int unsigned CNT_W = 5
) (
  input  logic [1:0]       sel_i,
  input  logic             fifo_en_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             reached_o,
  output logic             below_o
);
  logic [CNT_W-1:0] lvl;

  assign lvl       = fifo_en_i ? CNT_W'(rcq_pkg::trig_level(sel_i)) : CNT_W'(1);
  assign reached_o = (count_i >= lvl);
  assign below_o   = (count_i != '0) && !reached_o;
endmodule

// File: rtl/rcq_timer.sv
module rcq_timer #(
  parameter int unsigned TICKS = 40,
  localparam int unsigned CW   = $clog2(TICKS)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic restart_i,
  input  logic tick_i,
  output logic expired_o
);
  logic [CW-1:0] cnt_q;
  logic          exp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (restart_i || !arm_i) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (tick_i && !exp_q) begin
      if (cnt_q == CW'(TICKS - 1)) begin
        cnt_q <= '0;
        exp_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assign expired_o = exp_q;
endmodule

// File: rtl/rx_char_queue.sv
module rx_char_queue #(
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned DEPTH         = 16,
  parameter int unsigned BITS_PER_CHAR = 10,
  parameter int unsigned TO_CHARS      = 4,
  localparam int unsigned CNT_W        = $clog2(DEPTH + 1),
  localparam int unsigned TO_TICKS     = BITS_PER_CHAR * TO_CHARS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_en_i,
  input  logic              flush_i,
  input  logic [1:0]        trig_sel_i,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              overrun_o,
  output logic              data_irq_o,
  output logic              timeout_irq_o
);
  logic en_q, clr, wr_ok, rd_ok, below, ovr_q;

  // mode switch empties the queue
  assign clr = flush_i || (fifo_en_i != en_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      en_q <= fifo_en_i;
      if (flush_i)                          ovr_q <= 1'b0;
      else if (wr_i && !wr_ok && !clr)      ovr_q <= 1'b1;
    end
  end

  rcq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .cap_one_i (!fifo_en_i),
    .wr_i      (wr_i),
    .wr_data_i (wr_data_i),
    .rd_i      (rd_i),
    .rd_data_o (rd_data_o),
    .count_o   (count_o),
    .full_o    (full_o),
    .empty_o   (empty_o),
    .wr_ok_o   (wr_ok),
    .rd_ok_o   (rd_ok)
  );

  rcq_trigger #(.CNT_W(CNT_W)) u_trig (
    .sel_i     (trig_sel_i),
    .fifo_en_i (fifo_en_i),
    .count_i   (count_o),
    .reached_o (data_irq_o),
    .below_o   (below)
  );

  rcq_timer #(.TICKS(TO_TICKS)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .arm_i     (fifo_en_i && below),
    .restart_i (wr_i || rd_ok || clr),
    .tick_i    (tick_i),
    .expired_o (timeout_irq_o)
  );

  assign overrun_o = ovr_q;
endmodule

// File: rtl/rcq_checker.sv
module rcq_checker #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fifo_en_i,
  input logic             flush_i,
  input logic [1:0]       trig_sel_i,
  input logic             wr_i,
  input logic             rd_i,
  input logic [CNT_W-1:0] count_o,
  input logic             empty_o,
  input logic             full_o,
  input logic             overrun_o,
  input logic             data_irq_o,
  input logic             timeout_irq_o
);
  p_count_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(DEPTH));

  p_full_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && wr_i && !rd_i && !flush_i && $stable(fifo_en_i)
    |=> overrun_o && count_o == $past(count_o));

  p_overrun_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o && !flush_i |=> overrun_o);

  p_empty_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && rd_i && !wr_i |=> empty_o);

  p_irq_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(data_irq_o) && $stable(trig_sel_i) && $stable(fifo_en_i) |-> $past(wr_i));

  p_no_timeout_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_en_i |=> !timeout_irq_o);

  p_timeout_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i || (rd_i && !empty_o) |=> !timeout_irq_o);

  p_flush_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o && !overrun_o && !timeout_irq_o);
endmodule

bind rx_char_queue rcq_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .fifo_en_i     (fifo_en_i),
  .flush_i       (flush_i),
  .trig_sel_i    (trig_sel_i),
  .wr_i          (wr_i),
  .rd_i          (rd_i),
  .count_o       (count_o),
  .empty_o       (empty_o),
  .full_o        (full_o),
  .overrun_o     (overrun_o),
  .data_irq_o    (data_irq_o),
  .timeout_irq_o (timeout_irq_o)
);

// File: tb/sim_rx_char_queue.sv
`timescale 1ns/1ps
module sim_rx_char_queue;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_en = 1'b1, flush = 1'b0, tick = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [1:0] trig = 2'b00;
  logic [7:0] wdat = 8'h00;
  logic [7:0] rdat;
  logic [4:0] cnt;
  logic       empty, full, ovr, dirq, tirq;
  int         n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  rx_char_queue u0 (
    .clk_i(clk), .rst_ni(rst_n), .fifo_en_i(fifo_en), .flush_i(flush),
    .trig_sel_i(trig), .tick_i(tick), .wr_i(wr), .wr_data_i(wdat), .rd_i(rd),
    .rd_data_o(rdat), .count_o(cnt), .empty_o(empty), .full_o(full),
    .overrun_o(ovr), .data_irq_o(dirq), .timeout_irq_o(tirq)
  );

  typedef struct packed {
    logic       wr;
    logic       rd;
    logic [1:0] trig;
    logic [7:0] data;
    logic [4:0] cnt;
    logic       irq;
    logic [7:0] head;
  } vec_t;

  // R2 R4 R5: order, count and threshold, results after the edge
  localparam vec_t VEC [12] = '{
    '{1'b1, 1'b0, 2'b01, 8'hA0, 5'd1, 1'b0, 8'hA0},
    '{1'b1, 1'b0, 2'b01, 8'hA1, 5'd2, 1'b0, 8'hA0},
    '{1'b1, 1'b0, 2'b01, 8'hA2, 5'd3, 1'b0, 8'hA0},
    '{1'b1, 1'b0, 2'b01, 8'hA3, 5'd4, 1'b1, 8'hA0},
    '{1'b0, 1'b1, 2'b01, 8'h00, 5'd3, 1'b0, 8'hA1},
    '{1'b0, 1'b0, 2'b00, 8'h00, 5'd3, 1'b1, 8'hA1},
    '{1'b1, 1'b1, 2'b00, 8'hA4, 5'd3, 1'b1, 8'hA2},
    '{1'b0, 1'b0, 2'b10, 8'h00, 5'd3, 1'b0, 8'hA2},
    '{1'b0, 1'b1, 2'b10, 8'h00, 5'd2, 1'b0, 8'hA3},
    '{1'b0, 1'b1, 2'b10, 8'h00, 5'd1, 1'b0, 8'hA4},
    '{1'b0, 1'b1, 2'b00, 8'h00, 5'd0, 1'b0, 8'h00},
    '{1'b0, 1'b1, 2'b00, 8'h00, 5'd0, 1'b0, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) cyc();
    tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 count", cnt, 0);
    chk("R1 empty", empty, 1);
    chk("R1 flags", {full, ovr, dirq, tirq}, 4'b0000);
    rst_n = 1'b1;
    repeat (2) cyc();

    for (int i = 0; i < 12; i++) begin
      wr = VEC[i].wr; rd = VEC[i].rd; trig = VEC[i].trig; wdat = VEC[i].data;
      cyc();
      wr = 1'b0; rd = 1'b0;
      chk($sformatf("R2 count vec%0d", i), cnt, VEC[i].cnt);
      chk($sformatf("R5 irq vec%0d", i), dirq, VEC[i].irq);
      if (VEC[i].cnt != 0) chk($sformatf("R2 head vec%0d", i), rdat, VEC[i].head);
      else chk($sformatf("R4 empty vec%0d", i), empty, 1);
    end

    // R5 R2 R3: fill to capacity at threshold 14
    trig = 2'b11;
    for (int i = 0; i < 16; i++) begin
      wr = 1'b1; wdat = 8'(i);
      cyc();
      if (i == 12) chk("R5 below 14", dirq, 0);
      if (i == 13) chk("R5 at 14", dirq, 1);
      if (i == 14) chk("R2 not full at 15", full, 0);
    end
    chk("R2 full at 16", full, 1);
    chk("R3 no overrun yet", ovr, 0);
    wdat = 8'hEE;
    cyc();
    wr = 1'b0;
    chk("R3 overrun set", ovr, 1);
    chk("R3 count kept", cnt, 16);
    cyc();
    chk("R3 overrun sticky", ovr, 1);
    for (int i = 0; i < 16; i++) begin
      chk("R3 R2 order", rdat, 8'(i));
      rd = 1'b1;
      cyc();
      rd = 1'b0;
    end
    chk("R2 drained", empty, 1);
    flush = 1'b1;
    cyc();
    flush = 1'b0;
    chk("R9 flush clears overrun", ovr, 0);

    // R9 mode change empties; R6 single holding register
    wr = 1'b1; wdat = 8'h11; cyc(); wdat = 8'h22; cyc(); wr = 1'b0;
    chk("R9 pre count", cnt, 2);
    fifo_en = 1'b0; trig = 2'b11;
    cyc();
    chk("R9 mode change empties", cnt, 0);
    wr = 1'b1; wdat = 8'h55; cyc(); wr = 1'b0;
    chk("R6 full at 1", full, 1);
    chk("R6 threshold 1", dirq, 1);
    wr = 1'b1; wdat = 8'h66; cyc(); wr = 1'b0;
    chk("R6 extra dropped", {cnt, rdat}, {5'd1, 8'h55});
    chk("R6 R3 overrun", ovr, 1);
    ticks(60);
    chk("R6 no timeout", tirq, 0);
    rd = 1'b1; cyc(); rd = 1'b0;
    chk("R6 read empties", empty, 1);
    flush = 1'b1; cyc(); flush = 1'b0;
    fifo_en = 1'b1; trig = 2'b10;
    cyc();

    // R7 R8 timeout at 40 ticks below threshold 8
    wr = 1'b1; wdat = 8'h31; cyc(); wdat = 8'h32; cyc(); wr = 1'b0;
    ticks(39);
    chk("R7 no timeout at 39", tirq, 0);
    ticks(1);
    chk("R7 timeout at 40", tirq, 1);
    rd = 1'b1; cyc(); rd = 1'b0;
    chk("R8 read clears", tirq, 0);
    chk("R8 count after read", cnt, 1);
    ticks(39);
    chk("R8 restarted 39", tirq, 0);
    ticks(1);
    chk("R8 restarted 40", tirq, 1);
    wr = 1'b1; wdat = 8'h33; cyc(); wr = 1'b0;
    chk("R8 write clears", tirq, 0);
    ticks(40);
    chk("R7 second expiry", tirq, 1);
    flush = 1'b1; cyc(); flush = 1'b0;
    chk("R9 flush clears timeout", {cnt, tirq}, {5'd0, 1'b0});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule